// File: doc/BRIEF.md
# 100 Mbps Nibble-Mode Reduced-Pin Ethernet Transmit Encoder

This block sits on the MAC side of a reduced-pin Ethernet link running at 100 Mbps. It takes whole bytes from the MAC through a valid/ready handshake, each byte carrying an error flag. It sends each byte as two 4-bit nibbles on the data pins, low nibble first, one nibble per period of the forwarded transmit clock. It also generates that transmit clock by dividing the core clock. Each nibble is held for a whole transmit clock period, because the receiver samples data on the rising edge only.

A single control pin carries two levels per transmit clock period. The level in the high half of the period says whether a frame is being sent. The level in the low half, combined with the first, tells data apart from error propagation. The encodings are:
- idle: low, then low
- data: high, then low
- error propagation: high, then high

The fourth combination, low then high, is reserved and is never produced. Between frames, and whenever no byte is offered in a byte slot, the data pins carry 0000.

The core clock must run at four times the transmit clock rate or faster. A 100 MHz core with the default divider gives a 25 MHz transmit clock.

Top module: `tx_nib_enc`

## Requirements
- R1: While `rst` is high, at every core clock edge, `txc`, `txd`, `tx_ctl` and `in_ready` are all driven low.
- R2: `txc` has a period of 2*HALF_CYC core clock cycles. It is high for the first HALF_CYC cycles of each period and low for the rest (default HALF_CYC=2, giving 25 MHz from a 100 MHz core).
- R3: `in_ready` is high for exactly one core cycle in every two `txc` periods. That cycle is the last core cycle before a `txc` rising edge that starts a byte slot. A byte is accepted on a core edge where `in_valid` and `in_ready` are both high.
- R4: An accepted byte shows bits [3:0] on `txd` for the whole `txc` period that starts at the next `txc` rising edge. It then shows bits [7:4] for the whole following period.
- R5: For an accepted byte with `in_err`=0, `tx_ctl` is high during the high half of `txc` and low during the low half, in both of the byte's periods.
- R6: For an accepted byte with `in_err`=1, `tx_ctl` is high during both halves of both of the byte's periods.
- R7: In a byte slot where no byte is accepted, `txd` is 0000 and `tx_ctl` is low through both periods.
- R8: `tx_ctl` never takes the low-then-high combination within one `txc` period. It changes only at `txc` edges.
- R9: `in_valid`, `in_data` and `in_err` have no effect on the line outputs while `in_ready` is low. Bits [7:4] of an accepted byte come from the value held at acceptance.
- R10: Bytes accepted in consecutive slots are sent with no idle period between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, 2*HALF_CYC times the transmit clock rate |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte offered by the MAC |
| in_valid | input | 1 | `in_data`/`in_err` hold a byte to send |
| in_err | input | 1 | Send this byte with error propagation |
| in_ready | output | 1 | One-cycle pulse; the byte is taken on this edge if valid |
| txc | output | 1 | Forwarded transmit clock |
| txd | output | 4 | Transmit data nibble |
| tx_ctl | output | 1 | Transmit control line, two encoded levels per `txc` period |

## Verification
The hardest situation to reach is a change of encoding between adjacent byte slots with no idle gap: an error byte directly followed by a clean byte, and the reverse. Only in that case must the low-half level of `tx_ctl` drop or rise while its high-half level stays high. The stimulus keeps `in_valid` asserted and presents the next byte in the same sample in which `in_ready` is seen. Garbage on `in_data`/`in_err`, with `in_valid` high, is driven through the cycles when `in_ready` is low. This shows that only the byte taken at the handshake reaches the line.

// File: rtl/tx_nib_pkg.sv
package tx_nib_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  // What one transmit clock period will carry
  typedef struct packed {
    logic             en;
    logic             err;
    logic [NIB_W-1:0] nib;
  } nib_slot_t;
endpackage

// File: rtl/tx_nib_phase.sv
// Core-clock divider: forwarded clock, period events and byte-slot cadence
module tx_nib_phase #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  output logic start_ev,
  output logic fall_ev,
  output logic slot_hi,
  output logic txc_q,
  output logic rdy_q
);
  localparam int PER   = 2 * HALF_CYC;
  localparam int CNT_W = (PER > 2) ? $clog2(PER) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PER - 1);
  localparam logic [CNT_W-1:0] FALLC = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] RSTC  = CNT_W'(HALF_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             slot_q, slot_nx;

  assign start_ev = (cnt_q == LAST);
  assign fall_ev  = (cnt_q == FALLC);
  assign slot_hi  = slot_q;

  always_comb begin
    cnt_nx  = start_ev ? '0 : cnt_q + 1'b1;
    slot_nx = start_ev ? ~slot_q : slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= RSTC;
      slot_q <= 1'b1;
      txc_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      slot_q <= slot_nx;
      if (start_ev)     txc_q <= 1'b1;
      else if (fall_ev) txc_q <= 1'b0;
      rdy_q <= (cnt_nx == LAST) && slot_nx;
    end
  end
endmodule

// File: rtl/tx_nib_seq.sv
// Byte capture and nibble ordering
module tx_nib_seq
  import tx_nib_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ev,
  input  logic              slot_hi,
  input  logic              rdy,
  input  logic              in_valid,
  input  logic              in_err,
  input  logic [BYTE_W-1:0] in_data,
  output nib_slot_t         nxt
);
  logic             hold_en_q, hold_err_q;
  logic [NIB_W-1:0] hold_hi_q;
  logic             take;

  assign take = in_valid && rdy;

  always_comb begin
    if (slot_hi) begin
      nxt.en  = take;
      nxt.err = in_err;
      nxt.nib = in_data[NIB_W-1:0];
    end else begin
      nxt.en  = hold_en_q;
      nxt.err = hold_err_q;
      nxt.nib = hold_hi_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_en_q  <= 1'b0;
      hold_err_q <= 1'b0;
      hold_hi_q  <= '0;
    end else if (start_ev && slot_hi) begin
      hold_en_q  <= take;
      hold_err_q <= in_err;
      hold_hi_q  <= in_data[BYTE_W-1:NIB_W];
    end
  end
endmodule

// File: rtl/tx_nib_line.sv
// Output registers: nibble plus two-level control line
module tx_nib_line
  import tx_nib_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ev,
  input  logic             fall_ev,
  input  nib_slot_t        nxt,
  output logic [NIB_W-1:0] txd_q,
  output logic             ctl_q
);
  logic rise_q, fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      ctl_q  <= 1'b0;
    end else if (start_ev) begin
      txd_q  <= nxt.en ? nxt.nib : '0;
      rise_q <= nxt.en;
      fall_q <= nxt.en && nxt.err;
      ctl_q  <= nxt.en;
    end else if (fall_ev) begin
      // second level: error only on top of a high first level
      ctl_q <= rise_q && fall_q;
    end
  end
endmodule

// File: rtl/tx_nib_enc.sv
module tx_nib_enc
  import tx_nib_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_err,
  output logic              in_ready,
  output logic              txc,
  output logic [NIB_W-1:0]  txd,
  output logic              tx_ctl
);
  logic      start_ev, fall_ev, slot_hi, rdy;
  nib_slot_t nxt;

  tx_nib_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst(rst), .start_ev(start_ev), .fall_ev(fall_ev),
    .slot_hi(slot_hi), .txc_q(txc), .rdy_q(rdy)
  );

  tx_nib_seq u_seq (
    .clk(clk), .rst(rst), .start_ev(start_ev), .slot_hi(slot_hi),
    .rdy(rdy), .in_valid(in_valid), .in_err(in_err), .in_data(in_data),
    .nxt(nxt)
  );

  tx_nib_line u_line (
    .clk(clk), .rst(rst), .start_ev(start_ev), .fall_ev(fall_ev),
    .nxt(nxt), .txd_q(txd), .ctl_q(tx_ctl)
  );

  assign in_ready = rdy;
endmodule

// File: rtl/tx_nib_chk.sv
module tx_nib_chk
  import tx_nib_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             txc,
  input logic [NIB_W-1:0] txd,
  input logic             tx_ctl
);
  p_txc_high_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(txc) |=> txc);

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  p_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ($rose(txc) && tx_ctl));

  p_txd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $rose(txc));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(txc) && !tx_ctl) |-> (txd == '0));

  p_no_reserved_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(txc) && tx_ctl) |-> $past(tx_ctl));

  p_ctl_edges_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_ctl) |-> ($rose(txc) || $fell(txc)));
endmodule

bind tx_nib_enc tx_nib_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .txc(txc), .txd(txd), .tx_ctl(tx_ctl)
);

// File: tb/sim_tx_nib_enc.sv
module sim_tx_nib_enc;
  localparam int HC  = 2;
  localparam int PER = 2 * HC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_err = 1'b0;
  logic       in_ready, txc, tx_ctl;
  logic [3:0] txd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  tx_nib_enc #(.HALF_CYC(HC)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_err(in_err), .in_ready(in_ready), .txc(txc), .txd(txd), .tx_ctl(tx_ctl)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp finish", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int expv);
    checks = checks + 1;
    if (act != expv) begin
      errors = errors + 1;
      $display("FAIL %s: act %0h exp %0h at %0t", tag, act, expv, $time);
    end
  endtask

  // One byte slot: offer (v,d,e), wait for the handshake, check two periods.
  // noisy drives garbage with valid high while ready is low (R9).
  task automatic run_slot(bit v, logic [7:0] d, bit e, bit noisy);
    in_valid = v; in_data = d; in_err = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    for (int k = 0; k < 2 * PER; k++) begin
      @(negedge clk);
      if (k == 0) begin
        in_valid = noisy; in_data = ~d; in_err = ~e;
      end
      begin
        int  p  = k / PER;
        int  ph = k % PER;
        bit  hi = (ph < HC);
        int  en = v ? ((p == 0) ? d[3:0] : d[7:4]) : 0;
        chk("R2 txc", txc, hi);
        chk("R3 in_ready", in_ready, (k == 2 * PER - 1));
        if (v) begin
          chk(noisy ? "R9 txd held" : "R4 txd nibble", txd, en);
          chk(e ? "R6 ctl error" : "R5 ctl data", tx_ctl, hi ? 1 : e);
        end else begin
          chk("R7 idle txd", txd, 0);
          chk("R7 idle ctl", tx_ctl, 0);
        end
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 txc", txc, 0);
      chk("R1 txd", txd, 0);
      chk("R1 ctl", tx_ctl, 0);
      chk("R1 in_ready", in_ready, 0);
    end
    rst = 1'b0;
  endtask

  task automatic t_idle();
    run_slot(0, 8'h00, 0, 0);
    run_slot(0, 8'h5A, 1, 0);
  endtask

  task automatic t_single();
    run_slot(1, 8'hA5, 0, 0);
    run_slot(0, 8'h00, 0, 0);
    run_slot(1, 8'h3C, 1, 0);
    run_slot(0, 8'h00, 0, 0);
  endtask

  // R10: consecutive slots, encoding switching data<->error without gap
  task automatic t_stream_r10();
    run_slot(1, 8'h12, 0, 0);
    run_slot(1, 8'hF0, 1, 0);
    run_slot(1, 8'h0F, 0, 0);
    run_slot(1, 8'hE7, 1, 0);
    run_slot(1, 8'h81, 1, 0);
    run_slot(0, 8'h00, 0, 0);
  endtask

  task automatic t_ignore_r9();
    run_slot(1, 8'h96, 0, 1);
    run_slot(1, 8'h4B, 1, 1);
    run_slot(0, 8'h00, 0, 0);
  endtask

  // R8: scan many periods, no low-then-high pair in one period
  task automatic t_reserved_r8();
    bit lvl_hi = 0;
    int bad = 0;
    in_valid = 1; in_data = 8'hC3; in_err = 0;
    for (int i = 0; i < 16 * PER; i++) begin
      @(negedge clk);
      in_err = i[3];
      in_valid = (i % 24) < 16;
      if (txc) lvl_hi = tx_ctl;
      else if (!lvl_hi && tx_ctl) bad++;
    end
    chk("R8 reserved pairs", bad, 0);
    in_valid = 0;
    run_slot(0, 8'h00, 0, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_stream_r10();
    t_ignore_r9();
    t_reserved_r8();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule